// File: doc/BRIEF.md
# Selectable-Alignment Audio Word Shifter

This block pairs a transmit shift register with a receive shift register for fractional audio samples of up to 24 bits. A three-bit length code selects a word of 8, 12, 16, 20 or 24 bits. An alignment bit sets where the most significant bit of a word sits in the 24-bit parallel word. When the bit is clear, the MSB sits at bit 23. When it is set, the MSB sits at bit 15, which suits 16-bit fractional data.

On the transmit side, software-facing logic loads a parallel word into a holding register. At each word-start strobe the shifter copies the held word and sends its aligned bits out MSB first, one bit per bit-clock enable. On the receive side, the shifter collects the same number of serial bits. It then places the finished word at the selected alignment, clears every other bit, and signals completion with a one-cycle pulse. Frame timing and bit-clock generation come from outside the block.

A length/alignment pair that is not allowed raises an error flag. The behaviour then stays defined: the transmit line stays low for that word and the received word reads as zero.

Top module: `fws_top`

## Requirements
- R1: `cfg_err` is high exactly when `wlen_sel` is 5, 6 or 7, or when `align_alt` is 1 and `wlen_sel` is 3 or 4. The codes are 0=8, 1=12, 2=16, 3=20 and 4=24 bits.
- R2: The transmit MSB position P is 23 when `align_alt`=0 and 15 when `align_alt`=1. The first serial bit is the held word's bit P and appears on `tx_sd` in the cycle after a clock edge with `bit_en` and `word_start` both high. After the i-th following `bit_en` edge, `tx_sd` shows held bit P-i, for L bits in all.
- R3: `tx_sd` is low once the L bits of a word have been sent (from the L-th `bit_en` edge after the start edge onward). It is also low for the whole of a word started under a `cfg_err` configuration.
- R4: When `tx_load` and a word start share a clock edge, that word carries the previously held value. The newly loaded value goes out with the next word.
- R5: `rx_sd` is sampled on each `bit_en` edge, starting with the start edge, MSB first. The finished L-bit word is written to `rx_word` with its MSB at P, and every bit outside bits P..P-L+1 is zero.
- R6: `rx_done` is high for exactly one cycle: the cycle after the edge that captured the L-th bit. `rx_word` changes at that same time and then holds until the next completed word.
- R7: A word received under a `cfg_err` configuration still pulses `rx_done`, but `rx_word` is zero.
- R8: A word start during a word in progress restarts both the transmitter and the receiver. The abandoned receive word produces no `rx_done`.
- R9: While `bit_en` is low, neither shift register moves: `tx_sd` holds its value and no bit is sampled.
- R10: After reset, `tx_sd`, `rx_done` and `rx_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| align_alt | input | 1 | 1: MSB at bit 15; 0: MSB at bit 23 |
| wlen_sel | input | 3 | Word length code (0..4 = 8..24 bits) |
| tx_load | input | 1 | Load `tx_word` into the holding register |
| tx_word | input | 24 | Parallel word to transmit |
| bit_en | input | 1 | Bit-clock enable, one serial bit per high cycle |
| word_start | input | 1 | Marks the first bit of a word (qualified by `bit_en`) |
| rx_sd | input | 1 | Serial receive data |
| tx_sd | output | 1 | Serial transmit data |
| rx_word | output | 24 | Last completed received word, aligned |
| rx_done | output | 1 | One-cycle pulse when a received word completes |
| cfg_err | output | 1 | Length/alignment combination not allowed |

## Verification
Two pairs of functions can fall in the same cycle. The first is a parallel load and a word start. The bench provokes it by raising `tx_load` on the start edge and then checks that the serial bits come from the previous value, while the next word carries the new one. The second is a word start arriving partway through a receive word. The bench judges this by the absence of `rx_done` for the abandoned word and a correct, freshly aligned word from the restarted one. Every alignment and length code is swept against words computed arithmetically in the bench.

// File: rtl/fws_pkg.sv
package fws_pkg;
   localparam int DW       = 24;
   localparam int CW       = $clog2(DW + 1);
   localparam int SELW     = 3;
   localparam int LEN_MIN  = 8;
   localparam int LEN_STEP = 4;
   localparam int NUM_LEN  = 5;
   localparam int MSB_WIDE = DW - 1;
   localparam int MSB_ALT  = 15;

   typedef struct packed {
      logic [CW-1:0] len;
      logic [CW-1:0] msb;
      logic          err;
   } fws_cfg_t;
endpackage

// File: rtl/fws_cfg.sv
module fws_cfg
   import fws_pkg::*;
#(
   parameter int P_LEN_MIN  = LEN_MIN,
   parameter int P_LEN_STEP = LEN_STEP,
   parameter int P_NUM_LEN  = NUM_LEN,
   parameter int P_MSB_ALT  = MSB_ALT
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            align_alt,
   input  logic [SELW-1:0] wlen_sel,
   output fws_cfg_t        cfg
);
   localparam int LAST_LEN = P_LEN_MIN + P_LEN_STEP * (P_NUM_LEN - 1);

   if (LAST_LEN != DW) begin : g_bad_len
      $error("length table must end at the register width");
   end
   if (P_MSB_ALT + 1 < P_LEN_MIN) begin : g_bad_alt
      $error("alternate MSB too low for shortest word");
   end
   if (P_NUM_LEN > (1 << SELW)) begin : g_bad_sel
      $error("length code too narrow");
   end

   logic [CW-1:0] len_tab [P_NUM_LEN];
   for (genvar g = 0; g < P_NUM_LEN; g++) begin : g_len
      assign len_tab[g] = CW'(P_LEN_MIN + P_LEN_STEP * g);
   end

   logic          sel_ok;
   logic [CW-1:0] len_sel;

   always_comb begin
      sel_ok  = (int'(wlen_sel) < P_NUM_LEN);
      len_sel = CW'(P_LEN_MIN);
      for (int i = 0; i < P_NUM_LEN; i++) begin
         if (int'(wlen_sel) == i) len_sel = len_tab[i];
      end
      cfg.len = len_sel;
      cfg.msb = align_alt ? CW'(P_MSB_ALT) : CW'(MSB_WIDE);
      cfg.err = !sel_ok || (int'(len_sel) > int'(cfg.msb) + 1);
   end

   // R1: an accepted configuration always fits under its MSB
   a_r1_fits: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.err |-> (int'(cfg.len) <= int'(cfg.msb) + 1));
endmodule

// File: rtl/fws_tx.sv
module fws_tx
   import fws_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  fws_cfg_t      cfg,
   input  logic          tx_load,
   input  logic [DW-1:0] tx_word,
   input  logic          bit_en,
   input  logic          word_start,
   output logic          tx_sd
);
   logic [DW-1:0] hold_q;
   logic [DW-1:0] shr_q;
   logic [CW-1:0] left_q;
   logic [CW-1:0] msb_q;
   logic [CW-1:0] len_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (tx_load) begin
         hold_q <= tx_word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shr_q  <= '0;
         left_q <= '0;
         msb_q  <= CW'(MSB_WIDE);
         len_q  <= CW'(LEN_MIN);
         busy_q <= 1'b0;
      end else if (bit_en) begin
         if (word_start) begin
            shr_q  <= cfg.err ? '0 : hold_q;
            left_q <= cfg.len - 1'b1;
            msb_q  <= cfg.msb;
            len_q  <= cfg.len;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            if (left_q == '0) begin
               busy_q <= 1'b0;
            end else begin
               shr_q  <= shr_q << 1;
               left_q <= left_q - 1'b1;
            end
         end
      end
   end

   assign tx_sd = busy_q & shr_q[msb_q];

   // R3: remaining-bit count never reaches the latched length
   a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (left_q < len_q));
   // R9: without a bit enable the serial output stays put
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bit_en) |-> $stable(tx_sd));
endmodule

// File: rtl/fws_rx.sv
module fws_rx
   import fws_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  fws_cfg_t      cfg,
   input  logic          bit_en,
   input  logic          word_start,
   input  logic          rx_sd,
   output logic [DW-1:0] rx_word,
   output logic          rx_done
);
   logic [DW-1:0] acc_q;
   logic [CW-1:0] left_q;
   logic [CW-1:0] msb_q;
   logic [CW-1:0] len_q;
   logic          err_q;
   logic          busy_q;

   logic [DW-1:0] acc_nx;
   logic [DW-1:0] mask;
   logic [DW-1:0] placed;
   logic [CW-1:0] lsb_pos;

   always_comb begin
      acc_nx  = {acc_q[DW-2:0], rx_sd};
      mask    = {DW{1'b1}} >> (CW'(DW) - len_q);
      lsb_pos = msb_q + 1'b1 - len_q;
      placed  = err_q ? '0 : ((acc_nx & mask) << lsb_pos);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         left_q  <= '0;
         msb_q   <= CW'(MSB_WIDE);
         len_q   <= CW'(LEN_MIN);
         err_q   <= 1'b0;
         busy_q  <= 1'b0;
         rx_word <= '0;
         rx_done <= 1'b0;
      end else begin
         rx_done <= 1'b0;
         if (bit_en) begin
            if (word_start) begin
               acc_q  <= {{(DW-1){1'b0}}, rx_sd};
               left_q <= cfg.len - 1'b1;
               msb_q  <= cfg.msb;
               len_q  <= cfg.len;
               err_q  <= cfg.err;
               busy_q <= 1'b1;
            end else if (busy_q) begin
               acc_q  <= acc_nx;
               left_q <= left_q - 1'b1;
               if (left_q == CW'(1)) begin
                  busy_q  <= 1'b0;
                  rx_word <= placed;
                  rx_done <= 1'b1;
               end
            end
         end
      end
   end

   // R6: completion is a single-cycle pulse
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);
   // R5: nothing lands above the latched MSB
   a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> ((rx_word >> (msb_q + 1'b1)) == '0));
   // R7: an erroneous word reads back as zero
   a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && err_q) |-> (rx_word == '0));
   // R6: the word only moves together with the pulse
   a_r6_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_done |-> $stable(rx_word));
endmodule

// File: rtl/fws_top.sv
module fws_top
   import fws_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            align_alt,
   input  logic [SELW-1:0] wlen_sel,
   input  logic            tx_load,
   input  logic [DW-1:0]   tx_word,
   input  logic            bit_en,
   input  logic            word_start,
   input  logic            rx_sd,
   output logic            tx_sd,
   output logic [DW-1:0]   rx_word,
   output logic            rx_done,
   output logic            cfg_err
);
   fws_cfg_t cfg;

   fws_cfg u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .align_alt (align_alt),
      .wlen_sel  (wlen_sel),
      .cfg       (cfg)
   );

   fws_tx u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg        (cfg),
      .tx_load    (tx_load),
      .tx_word    (tx_word),
      .bit_en     (bit_en),
      .word_start (word_start),
      .tx_sd      (tx_sd)
   );

   fws_rx u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg        (cfg),
      .bit_en     (bit_en),
      .word_start (word_start),
      .rx_sd      (rx_sd),
      .rx_word    (rx_word),
      .rx_done    (rx_done)
   );

   assign cfg_err = cfg.err;
endmodule

// File: tb/fws_top_tb.sv
module fws_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        align_alt = 1'b0;
   logic [2:0]  wlen_sel = 3'd0;
   logic        tx_load = 1'b0;
   logic [23:0] tx_word = '0;
   logic        bit_en = 1'b0;
   logic        word_start = 1'b0;
   logic        rx_sd = 1'b0;
   logic        tx_sd;
   logic [23:0] rx_word;
   logic        rx_done;
   logic        cfg_err;

   int n_chk = 0;
   int n_bad = 0;
   logic [23:0] held = '0;

   always #2.5 clk = ~clk;

   fws_top u_dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit exp_err(input logic a, input logic [2:0] s);
      return (s > 3'd4) || (a && s > 3'd2);
   endfunction

   task automatic load(input logic [23:0] v);
      @(negedge clk);
      tx_load = 1'b1; tx_word = v;
      @(negedge clk);
      tx_load = 1'b0;
      held = v;
   endtask

   // one word, both directions; gap inserts an idle cycle after each bit
   task automatic run_word(input logic a, input logic [2:0] s, input logic [23:0] rxv,
                           input bit gap, input string tag);
      int L, P, sh;
      logic err;
      logic [23:0] expw, m, txv;
      L = 8 + 4 * ((s > 3'd4) ? 0 : int'(s));
      P = a ? 15 : 23;
      err = exp_err(a, s);
      txv = held;
      @(negedge clk);
      align_alt = a; wlen_sel = s;
      #0.1;
      chk("R1 cfg_err", {31'd0, cfg_err}, {31'd0, err});
      bit_en = 1'b1; word_start = 1'b1; rx_sd = rxv[L-1];
      for (int i = 0; i < L; i++) begin
         @(negedge clk);
         word_start = 1'b0;
         chk({tag, " R2/R3 tx bit"}, {31'd0, tx_sd}, {31'd0, err ? 1'b0 : txv[P-i]});
         if (i < L - 1) chk({tag, " R6 no early done"}, {31'd0, rx_done}, 32'd0);
         if (i < L - 1) rx_sd = rxv[L-2-i];
         if (gap && i < L - 1) begin
            bit_en = 1'b0;
            @(negedge clk);
            chk({tag, " R9 hold"}, {31'd0, tx_sd}, {31'd0, err ? 1'b0 : txv[P-i]});
            bit_en = 1'b1;
         end
      end
      m = 24'hFFFFFF >> (24 - L);
      sh = P + 1 - L;
      expw = err ? 24'd0 : ((rxv & m) << sh);
      chk({tag, " R6 done"}, {31'd0, rx_done}, 32'd1);
      chk({tag, " R5/R7 word"}, {8'd0, rx_word}, {8'd0, expw});
      @(negedge clk);
      bit_en = 1'b0;
      chk({tag, " R3 idle low"}, {31'd0, tx_sd}, 32'd0);
      chk({tag, " R6 pulse end"}, {31'd0, rx_done}, 32'd0);
      chk({tag, " R6 word held"}, {8'd0, rx_word}, {8'd0, expw});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 tx_sd", {31'd0, tx_sd}, 32'd0);
      chk("R10 rx_word", {8'd0, rx_word}, 32'd0);
      chk("R10 rx_done", {31'd0, rx_done}, 32'd0);
      rst_n = 1'b1;

      // R1 full decode sweep
      for (int a = 0; a < 2; a++) begin
         for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            align_alt = a[0]; wlen_sel = s[2:0];
            #0.1;
            chk("R1 decode", {31'd0, cfg_err}, {31'd0, exp_err(a[0], s[2:0])});
         end
      end

      // R2 R3 R5 R7 sweep all codes and alignments, several patterns
      for (int p = 0; p < 4; p++) begin
         for (int a = 0; a < 2; a++) begin
            for (int s = 0; s < 8; s++) begin
               logic [23:0] tv, rv;
               tv = 24'hA5C3_96 ^ (24'h13579B * (p + 1)) ^ (s << 5);
               rv = 24'h6B2D4F ^ (24'h2468AC * (p + 3)) ^ (a << 11);
               if (p == 0) begin tv = 24'hFFFFFF; rv = 24'hFFFFFF; end
               load(tv);
               run_word(a[0], s[2:0], rv, 1'b0, "sweep");
            end
         end
      end

      // R9 gapped bit enable
      load(24'h5AF00F);
      run_word(1'b1, 3'd2, 24'h00C3A5, 1'b1, "gap16");
      load(24'h81F7E3);
      run_word(1'b0, 3'd3, 24'h0B6D1E, 1'b1, "gap20");

      // R4 load coincides with word start
      load(24'h123456);
      @(negedge clk);
      align_alt = 1'b0; wlen_sel = 3'd4;
      bit_en = 1'b1; word_start = 1'b1; tx_load = 1'b1; tx_word = 24'hEDCBA9;
      rx_sd = 1'b0;
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         word_start = 1'b0; tx_load = 1'b0;
         chk("R4 old value", {31'd0, tx_sd}, {31'd0, held[23-i]});
      end
      @(negedge clk);
      bit_en = 1'b0;
      held = 24'hEDCBA9;
      run_word(1'b0, 3'd4, 24'h3C3C3C, 1'b0, "R4 next");

      // R8 restart mid-word
      @(negedge clk);
      align_alt = 1'b1; wlen_sel = 3'd0;
      bit_en = 1'b1; word_start = 1'b1; rx_sd = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         word_start = 1'b0;
         chk("R8 no done before restart", {31'd0, rx_done}, 32'd0);
      end
      load(24'h00AB00);
      run_word(1'b1, 3'd0, 24'h000096, 1'b0, "R8 restart");
      @(negedge clk);
      align_alt = 1'b0; wlen_sel = 3'd1;
      bit_en = 1'b1; word_start = 1'b1; rx_sd = 1'b1;
      repeat (6) @(negedge clk);
      word_start = 1'b0;
      load(24'h9F0000);
      bit_en = 1'b0;
      run_word(1'b0, 3'd1, 24'h000A5C, 1'b0, "R8 restart12");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule